// File: doc/BRIEF.md
# Perceptron Gradient-Descent Trainer

This block is a single neuron with two inputs. It can classify a sample and it can also train its own weights on chip. Each sample carries two signed fixed-point features and a one-bit target label. The block forms the weighted sum of the features plus a bias, passes that sum through an activation chosen at run time, and registers the result as its prediction. There are three activations: a hard threshold, a logistic curve read from a lookup table, and a rectifier. In inference mode that is all the block does.

In training mode the block also works out the gradient of the loss with respect to each of the three parameters. It does this with the chain rule: the loss slope times the activation slope gives the delta, and the delta times the partial of the sum gives each gradient. The gradients are summed across a minibatch of `BATCH` training samples. When the last sample of the batch arrives, every parameter moves once, by the learning rate times its summed gradient, and a one-cycle pulse marks that update. Initial parameters are loaded through ports. A restart strobe drops a partly collected batch.

All values use signed Q4.12 with `W = 16`, `FRAC = 12`, so 1.0 is 4096. Every product is rounded to nearest with ties toward positive infinity and then saturated. Sums saturate as well.

Top module: `pt_trainer`

## Requirements
- R1: After reset, y, w1, w2, b and done are all 0. When load_en is high at a clock edge, w1, w2 and b take init_w1, init_w2 and init_b, the batch progress and the gradient sums clear, and the new values are visible on the outputs after that edge.
- R2: The sum is s = sat(rnd(w1*x1) + rnd(w2*x2) + b). act_sel 00 selects the threshold, with y = 4096 when s >= 0 and y = 0 otherwise. act_sel 10 or 11 selects the rectifier, with y = s when s > 0 and y = 0 otherwise. y is registered at the edge where sample_valid is high and holds until the next valid sample.
- R3: act_sel 01 selects the logistic curve. For it, y = round(4096 / (1 + exp(-m))), where m = floor(s/256)/16. This is a 256-entry table spanning s from -8 to +8.
- R4: The activation slope used for training is rnd(y*(4096-y)) for the logistic curve, 4096 for the rectifier when s > 0 and 0 otherwise, and always 0 for the threshold. Training with the threshold therefore never moves a parameter.
- R5: loss_sel 0 selects square loss, with loss slope sat(2*(y - 4096*target)). loss_sel 1 minimises y itself, with loss slope 4096.
- R6: For each training sample, delta = rnd(loss slope * activation slope). The gradients are rnd(delta*x1) for w1, rnd(delta*x2) for w2 and delta for b. Each gradient is added into its own saturating sum.
- R7: Parameters hold their values during a batch. On the BATCH-th training sample, each parameter p becomes sat(p - rnd(eta*sum)), where sum includes that sample. done is high for exactly the one cycle after that edge, and the sums and the count clear.
- R8: A valid sample with mode_train low updates y only. It neither counts toward the batch nor changes any sum or parameter.
- R9: batch_start clears the sums and the count. If a training sample is valid in the same cycle, that sample becomes the first of the new batch.
- R10: The gradient sums and the parameters saturate at -32768 and 32767 and never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Load the initial parameters, which also clears the batch |
| init_w1 | input | W | Initial weight 1 |
| init_w2 | input | W | Initial weight 2 |
| init_b | input | W | Initial bias |
| eta | input | W | Learning rate |
| act_sel | input | 2 | Activation: 00 threshold, 01 logistic, 1x rectifier |
| loss_sel | input | 1 | 0 square loss, 1 minimise output |
| mode_train | input | 1 | 1 trains on the sample, 0 only infers |
| batch_start | input | 1 | Restart the minibatch |
| sample_valid | input | 1 | Sample present this cycle |
| x1 | input | W | Feature 1 |
| x2 | input | W | Feature 2 |
| target | input | 1 | Label of the sample |
| y | output | W | Registered prediction |
| w1 | output | W | Current weight 1 |
| w2 | output | W | Current weight 2 |
| b | output | W | Current bias |
| done | output | 1 | One-cycle pulse after a parameter update |

## Verification
Two functions can fall in the same cycle. In one, the restart strobe arrives with a valid training sample, so the sums must clear and take in that sample's gradient in one edge. In the other, the final sample of a batch must be added to the sums and used in the same edge's update. The bench provokes the first by sending a restart together with a sample part-way through a batch. It then judges that no update comes until BATCH further samples have arrived, counting the restarting sample as the first of them. The bench judges the second by comparing the parameters after done against a model that includes the last gradient.

// File: rtl/pt_pkg.sv
`timescale 1ns/1ps
package pt_pkg;

   typedef enum logic [1:0] {
      PT_ACT_STEP = 2'd0,
      PT_ACT_SIG  = 2'd1,
      PT_ACT_RELU = 2'd2
   } pt_act_e;

   // clamp a wide signed value into a w-bit signed range
   function automatic logic signed [63:0] sat_w(input logic signed [63:0] v, input int w);
      logic signed [63:0] hi;
      logic signed [63:0] lo;
      hi = (64'sd1 <<< (w - 1)) - 64'sd1;
      lo = -(64'sd1 <<< (w - 1));
      if (v > hi) return hi;
      if (v < lo) return lo;
      return v;
   endfunction

   // fixed-point product, rounded half-up, then saturated to w bits
   function automatic logic signed [63:0] rmul(input logic signed [63:0] a,
                                               input logic signed [63:0] m,
                                               input int frac, input int w);
      logic signed [63:0] p;
      p = a * m;
      p = (p + (64'sd1 <<< (frac - 1))) >>> frac;
      return sat_w(p, w);
   endfunction

endpackage

// File: rtl/pt_sigmoid_lut.sv
`timescale 1ns/1ps
module pt_sigmoid_lut #(
   parameter int W        = 16,
   parameter int FRAC     = 12,
   parameter int LUT_BITS = 8
) (
   input  logic signed [W-1:0] s,
   output logic signed [W-1:0] y
);
   localparam int  N     = 1 << LUT_BITS;
   localparam int  HALF  = N / 2;
   localparam int  SH    = FRAC - (LUT_BITS - 4);
   localparam real ONE_R = 2.0 ** FRAC;

   logic signed [W-1:0] tbl [N];

   // entries are filled at elaboration from the logistic curve over [-8, +8)
   for (genvar i = 0; i < N; i++) begin : g_ent
      localparam real MX  = (real'(i) - real'(HALF)) * 16.0 / real'(N);
      localparam int  VAL = $rtoi(ONE_R / (1.0 + $exp(-MX)) + 0.5);
      assign tbl[i] = W'(VAL);
   end

   logic signed [W-1:0] sc;
   logic signed [W-1:0] sc_cl;
   logic [LUT_BITS-1:0] idx;

   always_comb begin
      sc = s >>> SH;
      if (sc > W'(HALF - 1))      sc_cl = W'(HALF - 1);
      else if (sc < W'(-HALF))    sc_cl = W'(-HALF);
      else                        sc_cl = sc;
      idx = LUT_BITS'(sc_cl + W'(HALF));
   end

   assign y = tbl[idx];
endmodule

// File: rtl/pt_forward.sv
`timescale 1ns/1ps
module pt_forward
   import pt_pkg::*;
#(
   parameter int W        = 16,
   parameter int FRAC     = 12,
   parameter int LUT_BITS = 8
) (
   input  logic [1:0]          act,
   input  logic signed [W-1:0] w1,
   input  logic signed [W-1:0] w2,
   input  logic signed [W-1:0] b,
   input  logic signed [W-1:0] x1,
   input  logic signed [W-1:0] x2,
   output logic signed [W-1:0] s,
   output logic signed [W-1:0] y,
   output logic signed [W-1:0] dyds
);
   localparam logic signed [W-1:0] ONE_Q = W'(64'sd1 <<< FRAC);

   logic signed [W-1:0] p1, p2, y_sig;

   always_comb begin
      p1 = W'(rmul(64'(w1), 64'(x1), FRAC, W));
      p2 = W'(rmul(64'(w2), 64'(x2), FRAC, W));
      s  = W'(sat_w(64'(p1) + 64'(p2) + 64'(b), W));
   end

   pt_sigmoid_lut #(.W(W), .FRAC(FRAC), .LUT_BITS(LUT_BITS)) u_lut (
      .s (s),
      .y (y_sig)
   );

   always_comb begin
      case (pt_act_e'(act))
         PT_ACT_STEP: begin
            y    = (s >= 0) ? ONE_Q : '0;
            dyds = '0;
         end
         PT_ACT_SIG: begin
            y    = y_sig;
            dyds = W'(rmul(64'(y_sig), 64'(ONE_Q - y_sig), FRAC, W));
         end
         default: begin
            y    = (s > 0) ? s : '0;
            dyds = (s > 0) ? ONE_Q : '0;
         end
      endcase
   end
endmodule

// File: rtl/pt_lane.sv
`timescale 1ns/1ps
module pt_lane
   import pt_pkg::*;
#(
   parameter int W    = 16,
   parameter int FRAC = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic signed [W-1:0] init,
   input  logic                clr,
   input  logic                add,
   input  logic                upd,
   input  logic signed [W-1:0] grad,
   input  logic signed [W-1:0] eta,
   output logic signed [W-1:0] param
);
   logic signed [W-1:0] acc, acc_eff, sum, step;

   always_comb begin
      acc_eff = clr ? '0 : acc;
      sum     = W'(sat_w(64'(acc_eff) + 64'(grad), W));
      step    = W'(rmul(64'(eta), 64'(sum), FRAC, W));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc   <= '0;
         param <= '0;
      end else if (load) begin
         acc   <= '0;
         param <= init;
      end else if (add) begin
         if (upd) begin
            acc   <= '0;
            param <= W'(sat_w(64'(param) - 64'(step), W));
         end else begin
            acc   <= sum;
         end
      end else if (clr) begin
         acc <= '0;
      end
   end

   assert_param_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !add) |=> $stable(param));

   assert_acc_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !add && !clr) |=> $stable(acc));

   assert_acc_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (add && !load && !upd && !clr && acc >= 0 && grad >= 0) |=> (acc >= $past(acc)));
endmodule

// File: rtl/pt_trainer.sv
`timescale 1ns/1ps
module pt_trainer
   import pt_pkg::*;
#(
   parameter int W        = 16,
   parameter int FRAC     = 12,
   parameter int BATCH    = 4,
   parameter int LUT_BITS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_en,
   input  logic signed [W-1:0] init_w1,
   input  logic signed [W-1:0] init_w2,
   input  logic signed [W-1:0] init_b,
   input  logic signed [W-1:0] eta,
   input  logic [1:0]          act_sel,
   input  logic                loss_sel,
   input  logic                mode_train,
   input  logic                batch_start,
   input  logic                sample_valid,
   input  logic signed [W-1:0] x1,
   input  logic signed [W-1:0] x2,
   input  logic                target,
   output logic signed [W-1:0] y,
   output logic signed [W-1:0] w1,
   output logic signed [W-1:0] w2,
   output logic signed [W-1:0] b,
   output logic                done
);
   localparam int CW = $clog2(BATCH + 1);
   localparam logic signed [W-1:0] ONE_Q = W'(64'sd1 <<< FRAC);

   if (BATCH < 1)                  begin : g_chk_batch $error("BATCH must be at least 1"); end
   if (FRAC >= W - 1)              begin : g_chk_frac  $error("FRAC must leave integer bits"); end
   if (FRAC < LUT_BITS - 4)        begin : g_chk_lut   $error("LUT_BITS too large for FRAC"); end
   if (W > 32)                     begin : g_chk_w     $error("W limited to 32 bits"); end

   logic signed [W-1:0] params [3];
   logic signed [W-1:0] xin [2];
   logic signed [W-1:0] s_c, y_c, dyds_c, tq, err, delta;
   logic [CW-1:0] cnt, cnt_eff;
   logic train_fire, update;

   assign xin[0] = x1;
   assign xin[1] = x2;

   pt_forward #(.W(W), .FRAC(FRAC), .LUT_BITS(LUT_BITS)) u_fwd (
      .act  (act_sel),
      .w1   (params[0]),
      .w2   (params[1]),
      .b    (params[2]),
      .x1   (x1),
      .x2   (x2),
      .s    (s_c),
      .y    (y_c),
      .dyds (dyds_c)
   );

   always_comb begin
      tq    = target ? ONE_Q : '0;
      err   = loss_sel ? ONE_Q : W'(sat_w(64'sd2 * (64'(y_c) - 64'(tq)), W));
      delta = W'(rmul(64'(err), 64'(dyds_c), FRAC, W));
   end

   always_comb begin
      train_fire = sample_valid && mode_train && !load_en;
      cnt_eff    = batch_start ? '0 : cnt;
      update     = train_fire && (cnt_eff == CW'(BATCH - 1));
   end

   for (genvar k = 0; k < 3; k++) begin : g_lane
      logic signed [W-1:0] grad_k;
      logic signed [W-1:0] init_k;
      if (k == 2) begin : g_bias
         assign grad_k = delta;
         assign init_k = init_b;
      end else begin : g_wt
         assign grad_k = W'(rmul(64'(delta), 64'(xin[k]), FRAC, W));
         assign init_k = (k == 0) ? init_w1 : init_w2;
      end
      pt_lane #(.W(W), .FRAC(FRAC)) u_lane (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (load_en),
         .init  (init_k),
         .clr   (batch_start),
         .add   (train_fire),
         .upd   (update),
         .grad  (grad_k),
         .eta   (eta),
         .param (params[k])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         y    <= '0;
         done <= 1'b0;
      end else begin
         done <= update;
         if (sample_valid) y <= y_c;
         if (load_en)          cnt <= '0;
         else if (train_fire)  cnt <= update ? '0 : cnt_eff + CW'(1);
         else if (batch_start) cnt <= '0;
      end
   end

   assign w1 = params[0];
   assign w2 = params[1];
   assign b  = params[2];

   assert_cnt_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CW'(BATCH));

   assert_done_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(sample_valid && mode_train && !load_en));

   assert_infer_no_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_valid && !mode_train && !load_en && !batch_start) |=> $stable(cnt));

   if (BATCH > 1) begin : g_restart_chk
      assert_restart_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (batch_start && sample_valid && mode_train && !load_en) |=> (cnt == CW'(1)));
   end
endmodule

// File: tb/tb_pt_trainer.sv
`timescale 1ns/1ps
module tb_pt_trainer;
   localparam int W = 16, FRAC = 12, BATCH = 4, ONE = 4096;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic load_en = 0, loss_sel = 0, mode_train = 0, batch_start = 0, sample_valid = 0, target = 0;
   logic [1:0] act_sel = 2'd0;
   logic signed [W-1:0] init_w1 = 0, init_w2 = 0, init_b = 0, eta = 0, x1 = 0, x2 = 0;
   logic signed [W-1:0] y, w1, w2, b;
   logic done;

   pt_trainer #(.W(W), .FRAC(FRAC), .BATCH(BATCH)) dut (
      .clk(clk), .rst_n(rst_n), .load_en(load_en), .init_w1(init_w1), .init_w2(init_w2),
      .init_b(init_b), .eta(eta), .act_sel(act_sel), .loss_sel(loss_sel),
      .mode_train(mode_train), .batch_start(batch_start), .sample_valid(sample_valid),
      .x1(x1), .x2(x2), .target(target), .y(y), .w1(w1), .w2(w2), .b(b), .done(done)
   );

   int n_run = 0, n_fail = 0;
   bit ended = 0;
   int mw[3], macc[3], mcnt, m_y, m_done;

   function automatic int msat(longint v);
      if (v > 32767) return 32767;
      if (v < -32768) return -32768;
      return int'(v);
   endfunction

   function automatic int mrmul(int a, int c);
      return msat((longint'(a) * longint'(c) + 2048) >>> 12);
   endfunction

   task automatic chk(string tag, longint got, longint exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic check_outs(string tag);
      chk({tag, " y"}, y, m_y);
      chk({tag, " w1"}, w1, mw[0]);
      chk({tag, " w2"}, w2, mw[1]);
      chk({tag, " b"}, b, mw[2]);
      chk({tag, " done"}, done, m_done);
   endtask

   task automatic model_step(int a, int c, bit t, bit train, bit bs);
      int s, yy, d, e, dl, ce, sum;
      int g[3];
      bit upd;
      s = msat(longint'(mrmul(mw[0], a)) + mrmul(mw[1], c) + mw[2]);
      if (act_sel == 2'd0) begin
         yy = (s >= 0) ? ONE : 0; d = 0;
      end else if (act_sel == 2'd1) begin
         yy = $rtoi(4096.0 / (1.0 + $exp(-(real'(s >>> 8) / 16.0))) + 0.5);
         d = mrmul(yy, ONE - yy);
      end else begin
         yy = (s > 0) ? s : 0; d = (s > 0) ? ONE : 0;
      end
      m_y = yy;
      m_done = 0;
      if (train) begin
         e = loss_sel ? ONE : msat(2 * (longint'(yy) - (t ? ONE : 0)));
         dl = mrmul(e, d);
         g[0] = mrmul(dl, a); g[1] = mrmul(dl, c); g[2] = dl;
         ce = bs ? 0 : mcnt;
         upd = (ce == BATCH - 1);
         for (int k = 0; k < 3; k++) begin
            sum = msat(longint'(bs ? 0 : macc[k]) + g[k]);
            if (upd) begin
               mw[k] = msat(longint'(mw[k]) - mrmul(eta, sum));
               macc[k] = 0;
            end else macc[k] = sum;
         end
         mcnt = upd ? 0 : ce + 1;
         m_done = upd;
      end else if (bs) begin
         for (int k = 0; k < 3; k++) macc[k] = 0;
         mcnt = 0;
      end
   endtask

   task automatic do_load(int a, int c, int bb, string tag);
      init_w1 = W'(a); init_w2 = W'(c); init_b = W'(bb); load_en = 1;
      @(posedge clk); @(negedge clk);
      load_en = 0;
      mw[0] = a; mw[1] = c; mw[2] = bb;
      for (int k = 0; k < 3; k++) macc[k] = 0;
      mcnt = 0; m_done = 0;
      check_outs(tag);
   endtask

   task automatic do_sample(int a, int c, bit t, bit train, bit bs, string tag);
      x1 = W'(a); x2 = W'(c); target = t; mode_train = train; batch_start = bs;
      sample_valid = 1;
      model_step(a, c, t, train, bs);
      @(posedge clk); @(negedge clk);
      sample_valid = 0; batch_start = 0; mode_train = 0;
      check_outs(tag);
   endtask

   task automatic t_load();
      do_load(2048, -1024, 512, "R1 load");
   endtask

   task automatic t_infer_step();
      act_sel = 2'd0;
      do_load(ONE, -ONE, 0, "R1 load step");
      do_sample(2048, 2048, 0, 0, 0, "R2 step s=0");
      chk("R2 step boundary y", y, ONE);
      do_sample(1024, 2048, 0, 0, 0, "R2 step negative");
      chk("R8 infer no done", done, 0);
   endtask

   task automatic t_relu();
      act_sel = 2'd2;
      do_sample(3072, 1024, 0, 0, 0, "R2 relu positive");
      chk("R2 relu value", y, 2048);
      do_sample(1024, 3072, 0, 0, 0, "R2 relu negative");
      act_sel = 2'd3;
      do_sample(3072, 1024, 0, 0, 0, "R2 relu code 3");
   endtask

   task automatic t_sigmoid();
      act_sel = 2'd1;
      do_load(ONE, 0, 0, "R1 load sig");
      do_sample(0, 0, 0, 0, 0, "R3 sig zero");
      chk("R3 sig midpoint", y, 2048);
      do_sample(32767, 0, 0, 0, 0, "R3 sig top");
      do_sample(-32768, 0, 0, 0, 0, "R3 sig bottom");
      do_sample(5000, 1000, 0, 0, 0, "R3 sig mid");
   endtask

   task automatic t_train_sig();
      act_sel = 2'd1; loss_sel = 0; eta = 2048;
      do_load(2048, -1024, 512, "R1 load train");
      do_sample(3000, -2000, 1, 1, 0, "R6 sig sample1");
      do_sample(-2500, 1500, 0, 1, 0, "R6 sig sample2");
      do_sample(4000, 4000, 1, 0, 0, "R8 infer mid batch");
      do_sample(1000, 3500, 1, 1, 0, "R5 sig sample3");
      do_sample(-4000, -500, 0, 1, 0, "R7 sig update");
      chk("R7 done after last", done, 1);
      @(negedge clk);
      m_done = 0;
      check_outs("R7 done one cycle");
   endtask

   task automatic t_train_step();
      act_sel = 2'd0; eta = 4096;
      do_load(1024, 1024, -256, "R1 load step train");
      for (int i = 0; i < BATCH; i++) do_sample(2000 * i - 3000, 1500, i[0], 1, 0, "R4 step train");
      chk("R4 step w1 unchanged", w1, 1024);
   endtask

   task automatic t_raw_relu();
      act_sel = 2'd2; loss_sel = 1; eta = 1024;
      do_load(3000, 2000, 1000, "R1 load raw");
      for (int i = 0; i < BATCH; i++) do_sample(1500 + 300 * i, -700 + 500 * i, 0, 1, 0, "R5 raw loss");
      loss_sel = 0;
   endtask

   task automatic t_restart();
      act_sel = 2'd1; loss_sel = 0; eta = 3000;
      do_load(-1500, 2500, 0, "R1 load restart");
      do_sample(2000, 1000, 1, 1, 0, "R9 pre1");
      do_sample(-1000, 3000, 0, 1, 0, "R9 pre2");
      do_sample(2500, -2500, 1, 1, 1, "R9 restart with sample");
      do_sample(500, 500, 0, 1, 0, "R9 second");
      do_sample(-3000, 200, 1, 1, 0, "R9 third no update");
      chk("R9 no early done", done, 0);
      do_sample(1200, -1800, 0, 1, 0, "R9 fourth update");
      chk("R9 done after restart batch", done, 1);
      mode_train = 0; batch_start = 1;
      @(posedge clk); @(negedge clk);
      batch_start = 0;
      model_step(0, 0, 0, 0, 1);
      m_y = y;
   endtask

   task automatic t_saturate();
      act_sel = 2'd2; loss_sel = 1; eta = -512;
      do_load(4096, 0, 16384, "R1 load sat");
      for (int i = 0; i < BATCH; i++) do_sample(32767, 0, 0, 1, 0, "R10 acc sat");
      eta = -4096;
      for (int i = 0; i < BATCH; i++) do_sample(32767, 0, 0, 1, 0, "R10 param sat");
      chk("R10 w1 clamps high", w1, 32767);
      loss_sel = 0;
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      for (int k = 0; k < 3; k++) begin mw[k] = 0; macc[k] = 0; end
      mcnt = 0; m_y = 0; m_done = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check_outs("R1 reset");
      t_load();
      t_infer_step();
      t_relu();
      t_sigmoid();
      t_train_sig();
      t_train_step();
      t_raw_relu();
      t_restart();
      t_saturate();
      finish_run();
   end
endmodule